// File: doc/BRIEF.md
# Thermal Event Configuration and Output Controller

This block holds the 16-bit configuration word of a digital temperature monitor and generates the event pin from it. A host reads and writes the word through a single-register port. One write strobe carries a full word, and the read data always shows the current contents. The block also receives the latest temperature code and three limits: the upper and lower edges of the alarm window and the critical trip point. From these it decides whether an event condition exists. That condition then goes through an event state machine, which follows the condition in comparator mode and holds it in interrupt mode.

The event state machine has four states. In `EV_QUIET` no event is held. In `EV_FOLLOW` the event is active and tracks the condition. In `EV_LATCHED` an interrupt event is held until a clear is accepted. In `EV_SPENT` an interrupt has been cleared, and the machine waits for the condition to go away before it can raise a new interrupt. The transitions are these. Shutdown moves every state to `EV_QUIET`. From quiet, a condition moves to `EV_FOLLOW` in comparator mode or to `EV_LATCHED` in interrupt mode. From follow, the machine returns to quiet when the condition drops, and moves to latched when interrupt mode is selected. From latched, it moves to follow or quiet when comparator mode is selected (follow if the condition still holds). An accepted clear moves it to spent if the condition is still present, and to quiet otherwise. From spent, it returns to quiet when the condition ends or when comparator mode is selected.

The block also has three gating outputs. One enables the sensing path. The other two are write enables for the alarm-window limit registers and the critical limit register. Two sticky lock bits control these enables, and only reset clears the lock bits.

Top module: `thermev_ctrl`

## Requirements
- R1: After reset the read data is 0x0000, the event pin is high (inactive at active-low polarity), sensing is enabled and both threshold write enables are 1.
- R2: Bits 15..9 and bit 5 always read 0. Writes to bits 15..9 and to bit 4 have no effect.
- R3: Bits 3..0 are mode (bit 0, 1 = interrupt), polarity (bit 1, 1 = active high), critical-only (bit 2) and output enable (bit 3). A write loads them only if neither lock bit was set before that write. Otherwise they keep their value, while the other fields in the same write still update.
- R4: Writing 1 to bit 6 sets the window lock and writing 1 to bit 7 sets the critical lock. Writing 0 never clears either lock. While bit 6 is set the window-limit write enable is 0, and while bit 7 is set the critical-limit write enable is 0.
- R5: Bit 8 (shutdown) is cleared by any write with bit 8 = 0. A write with bit 8 = 1 sets it only when neither lock was set before the write. The sense-enable output is the inverse of bit 8.
- R6: The event condition is a signed comparison. It holds when temperature > critical, or, if bit 2 is 0, when temperature > upper or temperature < lower. There is no condition during shutdown.
- R7: In comparator mode the event becomes active one clock after the condition appears and inactive one clock after it ends.
- R8: In interrupt mode the event becomes active one clock after the condition appears and stays active after the condition ends. It is cleared by a write with bit 5 = 1. If the condition still holds when the clear is accepted, a new event is raised only after the condition ends and then returns.
- R9: A clear write has no effect while temperature > critical.
- R10: The event pin drives the bit-1 value while the event is active, bit 3 is 1 and shutdown is 0. In every other case it drives the inverse of bit 1.
- R11: Bit 4 reads 1 exactly when the pin is at its active level.
- R12: Entering shutdown discards any active or latched event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 16 | Configuration write word |
| rd_data | output | 16 | Current configuration word |
| temp_code | input | TW | Signed temperature code |
| upper_lim | input | TW | Signed upper window limit |
| lower_lim | input | TW | Signed lower window limit |
| crit_lim | input | TW | Signed critical limit |
| evt_pin | output | 1 | Event pin level |
| sense_en | output | 1 | Sensing path enable |
| win_thr_wr_en | output | 1 | Window-limit registers write enable |
| crit_thr_wr_en | output | 1 | Critical-limit register write enable |

## Verification
Two collisions are driven on purpose, each in a single clock. In the first, a clear write meets a temperature that is still above the critical limit while an interrupt is latched. The event must remain held on that edge, and it must fall on the edge where the same clear is issued with a cool temperature. In the second, one write sets a lock bit together with mode and shutdown bits. This shows that the lock state before the write decides those fields, and that a later write can still clear shutdown under lock. Both cases are judged by a behavioural model that is compared on every clock, and by directed checks read from the pin and the read data.

// File: rtl/thermev_pkg.sv
package thermev_pkg;
    localparam int CFG_W      = 16;
    localparam int B_MODE     = 0;
    localparam int B_POL      = 1;
    localparam int B_CRITONLY = 2;
    localparam int B_OE       = 3;
    localparam int B_STAT     = 4;
    localparam int B_CLR      = 5;
    localparam int B_LKWIN    = 6;
    localparam int B_LKCRIT   = 7;
    localparam int B_SHUT     = 8;
    localparam int RSV_LO     = 9;

    typedef enum logic [1:0] {
        EV_QUIET   = 2'd0,
        EV_FOLLOW  = 2'd1,
        EV_LATCHED = 2'd2,
        EV_SPENT   = 2'd3
    } ev_state_t;

    typedef struct packed {
        logic shut;
        logic lk_crit;
        logic lk_win;
        logic oe;
        logic crit_only;
        logic pol;
        logic irq_mode;
    } cfg_t;
endpackage

// File: rtl/thermev_cfg_reg.sv
module thermev_cfg_reg
    import thermev_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic             clr_req
);
    logic locked;

    assign locked  = cfg.lk_win | cfg.lk_crit;
    assign clr_req = wr_en & wr_data[B_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            // mode fields follow the lock state from before this write
            cfg.irq_mode  <= locked ? cfg.irq_mode  : wr_data[B_MODE];
            cfg.pol       <= locked ? cfg.pol       : wr_data[B_POL];
            cfg.crit_only <= locked ? cfg.crit_only : wr_data[B_CRITONLY];
            cfg.oe        <= locked ? cfg.oe        : wr_data[B_OE];
            // locks only accumulate
            cfg.lk_win    <= cfg.lk_win  | wr_data[B_LKWIN];
            cfg.lk_crit   <= cfg.lk_crit | wr_data[B_LKCRIT];
            // shutdown: clear always allowed, set only when unlocked
            cfg.shut      <= wr_data[B_SHUT] & (~locked | cfg.shut);
        end
    end
endmodule

// File: rtl/thermev_detect.sv
module thermev_detect #(
    parameter int TW = 13
) (
    input  logic [TW-1:0] temp_code,
    input  logic [TW-1:0] upper_lim,
    input  logic [TW-1:0] lower_lim,
    input  logic [TW-1:0] crit_lim,
    output logic          win_viol,
    output logic          crit_viol
);
    logic signed [TW-1:0] t_s, hi_s, lo_s, cr_s;

    assign t_s  = $signed(temp_code);
    assign hi_s = $signed(upper_lim);
    assign lo_s = $signed(lower_lim);
    assign cr_s = $signed(crit_lim);

    assign win_viol  = (t_s > hi_s) | (t_s < lo_s);
    assign crit_viol = (t_s > cr_s);
endmodule

// File: rtl/thermev_event_fsm.sv
module thermev_event_fsm
    import thermev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic crit_viol,
    input  logic irq_mode,
    input  logic shut,
    input  logic clr_req,
    output logic asserted
);
    ev_state_t st, st_nx;
    logic      clr_ok;

    assign clr_ok = clr_req & ~crit_viol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= EV_QUIET;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            EV_QUIET: begin
                if (shut)          st_nx = EV_QUIET;
                else if (cond)     st_nx = irq_mode ? EV_LATCHED : EV_FOLLOW;
            end
            EV_FOLLOW: begin
                if (shut || !cond) st_nx = EV_QUIET;
                else if (irq_mode) st_nx = EV_LATCHED;
            end
            EV_LATCHED: begin
                if (shut)          st_nx = EV_QUIET;
                else if (!irq_mode) st_nx = cond ? EV_FOLLOW : EV_QUIET;
                else if (clr_ok)   st_nx = cond ? EV_SPENT : EV_QUIET;
            end
            EV_SPENT: begin
                if (shut || !irq_mode || !cond) st_nx = EV_QUIET;
            end
        endcase
    end

    always_comb begin
        unique case (st)
            EV_FOLLOW, EV_LATCHED: asserted = 1'b1;
            EV_QUIET, EV_SPENT:    asserted = 1'b0;
        endcase
    end
endmodule

// File: rtl/thermev_ctrl.sv
module thermev_ctrl
    import thermev_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    input  logic [TW-1:0]    temp_code,
    input  logic [TW-1:0]    upper_lim,
    input  logic [TW-1:0]    lower_lim,
    input  logic [TW-1:0]    crit_lim,
    output logic             evt_pin,
    output logic             sense_en,
    output logic             win_thr_wr_en,
    output logic             crit_thr_wr_en
);
    localparam int RSV_W = CFG_W - RSV_LO;

    cfg_t cfg;
    logic clr_req, win_viol, crit_viol, cond, asserted, drive;

    thermev_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .clr_req (clr_req)
    );

    thermev_detect #(.TW(TW)) u_det (
        .temp_code (temp_code),
        .upper_lim (upper_lim),
        .lower_lim (lower_lim),
        .crit_lim  (crit_lim),
        .win_viol  (win_viol),
        .crit_viol (crit_viol)
    );

    assign cond = ~cfg.shut & (crit_viol | (~cfg.crit_only & win_viol));

    thermev_event_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (cond),
        .crit_viol (crit_viol),
        .irq_mode  (cfg.irq_mode),
        .shut      (cfg.shut),
        .clr_req   (clr_req),
        .asserted  (asserted)
    );

    assign drive          = asserted & cfg.oe & ~cfg.shut;
    assign evt_pin        = drive ? cfg.pol : ~cfg.pol;
    assign sense_en       = ~cfg.shut;
    assign win_thr_wr_en  = ~cfg.lk_win;
    assign crit_thr_wr_en = ~cfg.lk_crit;

    assign rd_data = {{RSV_W{1'b0}}, cfg.shut, cfg.lk_crit, cfg.lk_win,
                      1'b0, drive, cfg.oe, cfg.crit_only, cfg.pol, cfg.irq_mode};
endmodule

// File: rtl/thermev_chk.sv
module thermev_chk #(
    parameter int TW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [15:0]   rd_data,
    input logic          evt_pin,
    input logic [TW-1:0] temp_code,
    input logic [TW-1:0] crit_lim
);
    logic hot;
    assign hot = $signed(temp_code) > $signed(crit_lim);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[15:9] == 7'd0) && !rd_data[5]); // R2
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[6] || rd_data[7]) |=> $stable(rd_data[3:0])); // R3
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[6] && rd_data[7]) |=> (rd_data[6] && rd_data[7])); // R4
    AST_NO_SHUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) ((rd_data[6] || rd_data[7]) && !rd_data[8]) |=> !rd_data[8]); // R5
    AST_SHUT_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n) rd_data[8] |-> (evt_pin == !rd_data[1])); // R10
    AST_HOT_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[0] && rd_data[4] && hot && !wr_en) |=> rd_data[4]); // R9
endmodule

bind thermev_ctrl thermev_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .evt_pin   (evt_pin),
    .temp_code (temp_code),
    .crit_lim  (crit_lim)
);

// File: tb/sim_thermev_ctrl.sv
`timescale 1ns/1ps
module sim_thermev_ctrl;
    localparam int TW = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        evt_pin, sense_en, win_thr_wr_en, crit_thr_wr_en;
    int          t_i = 200, hi_i = 400, lo_i = 0, cr_i = 800;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    thermev_ctrl #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .temp_code(t_i[TW-1:0]), .upper_lim(hi_i[TW-1:0]), .lower_lim(lo_i[TW-1:0]),
        .crit_lim(cr_i[TW-1:0]), .evt_pin(evt_pin), .sense_en(sense_en),
        .win_thr_wr_en(win_thr_wr_en), .crit_thr_wr_en(crit_thr_wr_en)
    );

    // behavioural reference: ev 0 none, 1 tracking, 2 held, 3 cleared-waiting
    bit [3:0] m_ctl;
    bit       m_lw, m_lc, m_sh;
    int       m_ev;

    function automatic bit m_drive();
        return m_ctl[3] && !m_sh && (m_ev == 1 || m_ev == 2);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctl <= 0; m_lw <= 0; m_lc <= 0; m_sh <= 0; m_ev <= 0;
        end else begin
            automatic bit lk   = m_lw || m_lc;
            automatic bit hot  = t_i > cr_i;
            automatic bit win  = (t_i > hi_i) || (t_i < lo_i);
            automatic bit cnd  = !m_sh && (hot || (!m_ctl[2] && win));
            automatic bit intr = m_ctl[0];
            automatic bit clr  = wr_en && wr_data[5] && !hot;
            automatic int nx   = m_ev;
            if (m_sh) nx = 0;
            else if (m_ev == 0) nx = cnd ? (intr ? 2 : 1) : 0;
            else if (m_ev == 1) nx = !cnd ? 0 : (intr ? 2 : 1);
            else if (m_ev == 2) begin
                if (!intr) nx = cnd ? 1 : 0;
                else if (clr) nx = cnd ? 3 : 0;
            end else if (!intr || !cnd) nx = 0;
            m_ev <= nx;
            if (wr_en) begin
                if (!lk) m_ctl <= wr_data[3:0];
                m_lw <= m_lw || wr_data[6];
                m_lc <= m_lc || wr_data[7];
                if (!wr_data[8]) m_sh <= 0;
                else if (!lk) m_sh <= 1;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n) begin
        automatic bit d = m_drive();
        chk(rd_data[3:0] == m_ctl, "R3 mode fields", rd_data[3:0], m_ctl);
        chk(rd_data[6] == m_lw && rd_data[7] == m_lc, "R4 lock bits", rd_data[7:6], {m_lc, m_lw});
        chk(win_thr_wr_en == !m_lw && crit_thr_wr_en == !m_lc, "R4 thr enables",
            {win_thr_wr_en, crit_thr_wr_en}, {!m_lw, !m_lc});
        chk(rd_data[8] == m_sh && sense_en == !m_sh, "R5 shutdown", {rd_data[8], sense_en}, {m_sh, !m_sh});
        chk(rd_data[4] == d, "R11 status", rd_data[4], d);
        chk(rd_data[15:9] == 0 && rd_data[5] == 0, "R2 zero bits", rd_data, 0);
        chk(evt_pin == (d ? m_ctl[1] : !m_ctl[1]), "R10 pin level", evt_pin, d ? m_ctl[1] : !m_ctl[1]);
    end

    task automatic wr(logic [15:0] v);
        @(negedge clk); #1 wr_en = 1'b1; wr_data = v;
        @(negedge clk); #1 wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic settemp(int v);
        @(negedge clk); #1 t_i = v;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        chk(evt_pin && sense_en && win_thr_wr_en && crit_thr_wr_en, "R1 outputs",
            {evt_pin, sense_en, win_thr_wr_en, crit_thr_wr_en}, 4'hF);
        #1 rst_n = 1'b1;

        // comparator, active low: R6 R7
        wr(16'h0008);
        settemp(500);  chk(evt_pin == 0, "R7 assert upper", evt_pin, 0);
        settemp(200);  chk(evt_pin == 1, "R7 release", evt_pin, 1);
        settemp(-5);   chk(evt_pin == 0, "R6 below lower signed", evt_pin, 0);
        settemp(200);
        wr(16'h000C);  // critical only
        settemp(500);  chk(evt_pin == 1, "R6 critical-only ignores window", evt_pin, 1);
        settemp(900);  chk(evt_pin == 0 && rd_data[4], "R6 critical event", evt_pin, 0);
        settemp(200);
        // polarity and output enable: R10 R11
        wr(16'h000A);
        settemp(500);  chk(evt_pin == 1, "R10 active high", evt_pin, 1);
        wr(16'h0002);  chk(evt_pin == 0 && !rd_data[4], "R10 disabled inactive", evt_pin, 0);
        settemp(200);

        // interrupt mode: R8
        wr(16'h000B);
        settemp(500);  chk(evt_pin == 1, "R8 latch", evt_pin, 1);
        settemp(200);  chk(evt_pin == 1, "R8 held after cool", evt_pin, 1);
        wr(16'h002B);  chk(evt_pin == 0, "R8 cleared", evt_pin, 0);
        settemp(500);  chk(evt_pin == 1, "R8 relatch", evt_pin, 1);
        wr(16'h002B);  chk(evt_pin == 0, "R8 clear while warm", evt_pin, 0);
        settemp(500);  chk(evt_pin == 0, "R8 no re-raise while warm", evt_pin, 0);
        settemp(200);
        settemp(500);  chk(evt_pin == 1, "R8 raise after return", evt_pin, 1);
        settemp(200);  wr(16'h002B);
        // critical blocks clear: R9
        settemp(900);  chk(evt_pin == 1, "R9 hot latch", evt_pin, 1);
        wr(16'h002B);  chk(evt_pin == 1, "R9 clear ignored hot", evt_pin, 1);
        settemp(200);  wr(16'h002B); chk(evt_pin == 0, "R9 clear when cool", evt_pin, 0);
        // shutdown drops event: R12
        settemp(500);  chk(evt_pin == 1, "R12 pending", evt_pin, 1);
        wr(16'h010B);  chk(evt_pin == 0 && !sense_en, "R12 shutdown discards", evt_pin, 0);
        settemp(200);  wr(16'h000B);
        settemp(200);  chk(evt_pin == 0, "R12 nothing left", evt_pin, 0);

        // reserved and read-only bits: R2
        wr(16'hFE3B);  chk(rd_data == 16'h000B, "R2 ignored bits", rd_data, 16'h000B);
        // locks: R3 R4 R5
        wr(16'h004B);  chk(!win_thr_wr_en && crit_thr_wr_en, "R4 window lock", win_thr_wr_en, 0);
        wr(16'h0000);  chk(rd_data == 16'h004B, "R3 frozen under lock", rd_data, 16'h004B);
        wr(16'h0100);  chk(rd_data[8] == 0, "R5 no set under lock", rd_data[8], 0);
        wr(16'h0080);  chk(rd_data == 16'h00CB && !crit_thr_wr_en, "R4 both locks", rd_data, 16'h00CB);

        // restart; shutdown clear under lock: R1 R5
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); chk(rd_data == 16'h0, "R1 locks cleared by reset", rd_data, 0);
        #1 rst_n = 1'b1;
        wr(16'h0100);  chk(!sense_en, "R5 set unlocked", sense_en, 0);
        wr(16'h01C7);  chk(rd_data == 16'h01C7, "R5 same-write lock", rd_data, 16'h01C7);
        wr(16'h00CF);  chk(rd_data == 16'h00C7, "R3 fields frozen", rd_data, 16'h00C7);
        wr(16'h00C0);  chk(rd_data == 16'h00C7 && sense_en, "R5 clear under lock", rd_data, 16'h00C7);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule